// File: doc/BRIEF.md
# Receive Source Selector with Counter Test Pattern

This block sits in front of the frame capture stage of a wideband receiver. A two-bit mode input chooses what the capture stage sees. It can see the channelizer output or the raw bypass samples. It can also see a deterministic counter pattern, which replaces the received data so that the capture, packing and DMA path can be checked from end to end. Every choice uses the same beat format: four complex samples per clock. Each sample is 32 bits, with the real part in the low half and the imaginary part in the high half. The beat also carries valid, start-of-frame and end-of-frame strobes.

In counter mode, the real part of each lane carries a running sample count from 0 to FRAME_LEN-1. The count is consecutive across lanes and across beats. The imaginary part carries a frame index that steps once each time the sample count wraps. The software capture trigger clears both counters, so the first beat after a trigger starts frame 0 at sample 0, together with start-of-frame. The capture enable input gates every source. Outputs are registered with one clock of latency.

Top module: `rxsrc_sel`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `out_sof`, `out_eof` and `out_data` are all zero, and both pattern counters are cleared.
- R2: A counter beat puts lane k in `out_data[32k+31:32k]`. The real count sits in the low 16 bits and the frame index in the high 16 bits. Lane k carries the beat's base count plus k, and all lanes carry the same frame index.
- R3: Successive counter beats advance the base count by 4 and wrap from FRAME_LEN-4 to 0. In the flattened lane stream, each sample is therefore the previous one plus 1, except at the wrap, where the step is -(FRAME_LEN-1).
- R4: The frame index rises by exactly one on the beat where the sample count wraps to 0, and is held on all other beats. It is 16 bits wide and rolls over from 65535 to 0.
- R5: In counter mode, `out_sof` is high exactly on beats whose lane 0 count is 0. `out_eof` is high exactly on beats whose lane 0 count is FRAME_LEN-4, which is the beat carrying the last four counts of a frame.
- R6: With mode 2 (counter) selected, `cap_en` high and `sw_trig` low, a counter beat with `out_valid` high appears on the next clock, every clock without a gap.
- R7: `sw_trig` high clears both counters. In counter mode, the trigger clock produces no beat on the next clock. The trigger takes priority over a beat that would have ended or wrapped a frame. The next counter beat carries count 0, frame 0 and start-of-frame.
- R8: Mode encoding: 0 selects the channelizer, 1 the bypass, 2 the counter pattern, and 3 no source. A selected channelizer or bypass beat appears one clock later with the same data and strobes. Whenever `out_valid` is low, `out_data`, `out_sof` and `out_eof` are zero.
- R9: With `cap_en` low, the next clock shows no valid beat and zero data for every mode, and the counters hold their values.
- R10: While another mode is selected, the counters hold. On return to counter mode, the pattern resumes at the next count, without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Source select: 0 channelizer, 1 bypass, 2 counter, 3 none |
| cap_en | input | 1 | Capture enable, gates every source |
| sw_trig | input | 1 | Software capture trigger, clears the pattern counters |
| chan_data | input | 128 | Channelizer beat, four packed complex samples |
| chan_valid | input | 1 | Channelizer beat valid |
| chan_sof | input | 1 | Channelizer start-of-frame |
| chan_eof | input | 1 | Channelizer end-of-frame |
| byp_data | input | 128 | Bypass beat, four packed complex samples |
| byp_valid | input | 1 | Bypass beat valid |
| byp_sof | input | 1 | Bypass start-of-frame |
| byp_eof | input | 1 | Bypass end-of-frame |
| out_data | output | 128 | Selected beat to the capture stage |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output start-of-frame |
| out_eof | output | 1 | Output end-of-frame |

## Verification
In counter mode, the software trigger can arrive in the same clock as a beat that would otherwise advance, end or wrap a frame, so the clear and the advance fall in the same cycle. The bench provokes this in two ways. It waits until its own model reports that the next beat is the end-of-frame beat and fires the trigger on that clock. It also scatters triggers at random over a long counter-mode run in which capture enable toggles. The result is judged against a behavioural model. The model expects no beat on the clock after the trigger, and it expects the next beat to restart at count 0, frame 0, with start-of-frame and no frame increment.

// File: rtl/rxsrc_pkg.sv
package rxsrc_pkg;

  // Source selection codes on mode_sel
  typedef enum logic [1:0] {
    SRC_CHAN = 2'd0,
    SRC_BYP  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_OFF  = 2'd3
  } src_mode_e;

  // Strobes that travel with one beat
  typedef struct packed {
    logic valid;
    logic sof;
    logic eof;
  } beat_flags_t;

endpackage

// File: rtl/rxsrc_cntgen.sv
// Sample/frame counter state for the test pattern.
// Base count steps by LANES per beat and wraps at FRAME_LEN; frame index
// steps on the wrap and rolls over at its natural width.
module rxsrc_cntgen #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int SAMP_W    = 16,
  parameter int CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  output logic [CNT_W-1:0]  base_o,
  output logic [SAMP_W-1:0] frame_o,
  output logic              first_o,
  output logic              last_o
);

  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(FRAME_LEN - LANES);
  localparam logic [CNT_W-1:0] STEP      = CNT_W'(LANES);

  logic [CNT_W-1:0]  base_q;
  logic [SAMP_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      base_q  <= '0;
      frame_q <= '0;
    end else if (advance) begin
      if (base_q == LAST_BASE) begin
        base_q  <= '0;
        frame_q <= frame_q + SAMP_W'(1);
      end else begin
        base_q  <= base_q + STEP;
      end
    end
  end

  assign base_o  = base_q;
  assign frame_o = frame_q;
  assign first_o = (base_q == '0);
  assign last_o  = (base_q == LAST_BASE);

endmodule

// File: rtl/rxsrc_lanepack.sv
// Builds one beat of the counter pattern: lane k real = base + k,
// imaginary = frame index, real in the low half of each lane word.
module rxsrc_lanepack #(
  parameter int LANES  = 4,
  parameter int SAMP_W = 16,
  parameter int CNT_W  = 9,
  parameter int DATA_W = LANES * 2 * SAMP_W
) (
  input  logic [CNT_W-1:0]  base_i,
  input  logic [SAMP_W-1:0] frame_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int LANE_W = 2 * SAMP_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign data_o[k*LANE_W +: SAMP_W]          = SAMP_W'(base_i) + SAMP_W'(k);
    assign data_o[k*LANE_W + SAMP_W +: SAMP_W] = frame_i;
  end

endmodule

// File: rtl/rxsrc_outreg.sv
// Selects one of three sources, applies the capture gate, zeroes data
// and strobes for invalid beats, and registers the result.
module rxsrc_outreg
  import rxsrc_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  src_mode_e         mode,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] chan_data,
  input  beat_flags_t       chan_flags,
  input  logic [DATA_W-1:0] byp_data,
  input  beat_flags_t       byp_flags,
  input  logic [DATA_W-1:0] cnt_data,
  input  beat_flags_t       cnt_flags,
  output logic [DATA_W-1:0] out_data,
  output beat_flags_t       out_flags
);

  logic [DATA_W-1:0] sel_data;
  beat_flags_t       sel_flags;
  logic              take;

  always_comb begin
    sel_data  = '0;
    sel_flags = '0;
    unique case (mode)
      SRC_CHAN: begin sel_data = chan_data; sel_flags = chan_flags; end
      SRC_BYP:  begin sel_data = byp_data;  sel_flags = byp_flags;  end
      SRC_CNT:  begin sel_data = cnt_data;  sel_flags = cnt_flags;  end
      default:  begin sel_data = '0;        sel_flags = '0;         end
    endcase
    take = cap_en && sel_flags.valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      out_data        <= take ? sel_data : '0;
      out_flags.valid <= take;
      out_flags.sof   <= take && sel_flags.sof;
      out_flags.eof   <= take && sel_flags.eof;
    end
  end

endmodule

// File: rtl/rxsrc_sel.sv
module rxsrc_sel
  import rxsrc_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SAMP_W    = 16,
  parameter int FRAME_LEN = 512,
  parameter int DATA_W    = LANES * 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              cap_en,
  input  logic              sw_trig,
  input  logic [DATA_W-1:0] chan_data,
  input  logic              chan_valid,
  input  logic              chan_sof,
  input  logic              chan_eof,
  input  logic [DATA_W-1:0] byp_data,
  input  logic              byp_valid,
  input  logic              byp_sof,
  input  logic              byp_eof,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  src_mode_e         mode;
  logic              cnt_adv;
  logic [CNT_W-1:0]  cnt_base;
  logic [SAMP_W-1:0] cnt_frame;
  logic              cnt_first;
  logic              cnt_last;
  logic [DATA_W-1:0] cnt_data;
  beat_flags_t       chan_flags;
  beat_flags_t       byp_flags;
  beat_flags_t       cnt_flags;
  beat_flags_t       out_flags;

  assign mode    = src_mode_e'(mode_sel);
  // Trigger wins over a beat in the same clock
  assign cnt_adv = cap_en && (mode == SRC_CNT) && !sw_trig;

  assign chan_flags = '{valid: chan_valid, sof: chan_sof, eof: chan_eof};
  assign byp_flags  = '{valid: byp_valid,  sof: byp_sof,  eof: byp_eof};
  assign cnt_flags  = '{valid: cnt_adv,    sof: cnt_first, eof: cnt_last};

  rxsrc_cntgen #(
    .LANES(LANES), .FRAME_LEN(FRAME_LEN), .SAMP_W(SAMP_W), .CNT_W(CNT_W)
  ) u_cntgen (
    .clk(clk), .rst(rst), .clear(sw_trig), .advance(cnt_adv),
    .base_o(cnt_base), .frame_o(cnt_frame),
    .first_o(cnt_first), .last_o(cnt_last)
  );

  rxsrc_lanepack #(
    .LANES(LANES), .SAMP_W(SAMP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_lanepack (
    .base_i(cnt_base), .frame_i(cnt_frame), .data_o(cnt_data)
  );

  rxsrc_outreg #(
    .DATA_W(DATA_W)
  ) u_outreg (
    .clk(clk), .rst(rst), .mode(mode), .cap_en(cap_en),
    .chan_data(chan_data), .chan_flags(chan_flags),
    .byp_data(byp_data),   .byp_flags(byp_flags),
    .cnt_data(cnt_data),   .cnt_flags(cnt_flags),
    .out_data(out_data),   .out_flags(out_flags)
  );

  assign out_valid = out_flags.valid;
  assign out_sof   = out_flags.sof;
  assign out_eof   = out_flags.eof;

endmodule

// File: rtl/rxsrc_sel_chk.sv
module rxsrc_sel_chk #(
  parameter int LANES     = 4,
  parameter int SAMP_W    = 16,
  parameter int FRAME_LEN = 512,
  parameter int DATA_W    = LANES * 2 * SAMP_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_sel,
  input logic              cap_en,
  input logic              sw_trig,
  input logic [DATA_W-1:0] chan_data,
  input logic              chan_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eof
);

  localparam int               LANE_W    = 2 * SAMP_W;
  localparam logic [SAMP_W-1:0] LAST_CNT = SAMP_W'(FRAME_LEN - LANES);

  logic              req_beat;
  logic              beat_q;
  logic              beat_q2;
  logic [SAMP_W-1:0] lane0;
  logic [SAMP_W-1:0] frm;

  assign req_beat = cap_en && (mode_sel == 2'd2) && !sw_trig;
  assign lane0    = out_data[SAMP_W-1:0];
  assign frm      = out_data[LANE_W-1:SAMP_W];

  // Checker-side history: was the beat now on the output a counter beat
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= 1'b0;
      beat_q2 <= 1'b0;
    end else begin
      beat_q  <= req_beat;
      beat_q2 <= beat_q;
    end
  end

  // R6
  a_r6_cnt_valid: assert property (@(posedge clk) disable iff (rst)
    req_beat |=> out_valid);

  // R9
  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> (!out_valid && out_data == '0));

  // R7
  a_r7_no_beat: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && mode_sel == 2'd2) |=> !out_valid);

  // R7
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_trig) && req_beat) |=> (lane0 == '0 && frm == '0 && out_sof));

  // R2: per-lane offset and shared frame index
  for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
    a_r2_lane: assert property (@(posedge clk) disable iff (rst)
      beat_q |-> (out_data[k*LANE_W +: SAMP_W] == lane0 + SAMP_W'(k) &&
                  out_data[k*LANE_W + SAMP_W +: SAMP_W] == frm));
  end

  // R3
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (beat_q && beat_q2) |->
      lane0 == (($past(lane0) == LAST_CNT) ? '0 : $past(lane0) + SAMP_W'(LANES)));

  // R4
  a_r4_frame_step: assert property (@(posedge clk) disable iff (rst)
    (beat_q && beat_q2 && lane0 == '0) |-> frm == $past(frm) + SAMP_W'(1));

  // R4
  a_r4_frame_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_q && beat_q2 && lane0 != '0) |-> frm == $past(frm));

  // R5
  a_r5_sof: assert property (@(posedge clk) disable iff (rst)
    beat_q |-> (out_sof == (lane0 == '0)));

  // R5
  a_r5_eof: assert property (@(posedge clk) disable iff (rst)
    beat_q |-> (out_eof == (lane0 == LAST_CNT)));

  // R8
  a_r8_chan_pass: assert property (@(posedge clk) disable iff (rst)
    (cap_en && mode_sel == 2'd0 && chan_valid) |=>
      (out_valid && out_data == $past(chan_data)));

  // R8
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && !out_sof && !out_eof));

endmodule

bind rxsrc_sel rxsrc_sel_chk #(
  .LANES(LANES), .SAMP_W(SAMP_W), .FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .cap_en(cap_en),
  .sw_trig(sw_trig), .chan_data(chan_data), .chan_valid(chan_valid),
  .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof)
);

// File: tb/rxsrc_sel_bench.sv
module rxsrc_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int SAMP_W = 16;
  localparam int FL     = 512;
  localparam int SFL    = 8;
  localparam int DW     = LANES * 2 * SAMP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic cap_en = 1'b0, sw_trig = 1'b0;
  logic [DW-1:0] chan_data = '0, byp_data = '0;
  logic chan_valid = 0, chan_sof = 0, chan_eof = 0;
  logic byp_valid = 0, byp_sof = 0, byp_eof = 0;
  logic [DW-1:0] out_data;
  logic out_valid, out_sof, out_eof;
  logic [DW-1:0] s_data;
  logic s_valid, s_sof, s_eof;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxsrc_sel u_rxsrc_sel (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cap_en(cap_en), .sw_trig(sw_trig),
    .chan_data(chan_data), .chan_valid(chan_valid), .chan_sof(chan_sof), .chan_eof(chan_eof),
    .byp_data(byp_data), .byp_valid(byp_valid), .byp_sof(byp_sof), .byp_eof(byp_eof),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof)
  );

  // Short-frame copy, always in counter mode, used for the frame rollover
  rxsrc_sel #(.FRAME_LEN(SFL)) u_rxsrc_sel_small (
    .clk(clk), .rst(rst), .mode_sel(2'd2), .cap_en(1'b1), .sw_trig(1'b0),
    .chan_data('0), .chan_valid(1'b0), .chan_sof(1'b0), .chan_eof(1'b0),
    .byp_data('0), .byp_valid(1'b0), .byp_sof(1'b0), .byp_eof(1'b0),
    .out_data(s_data), .out_valid(s_valid), .out_sof(s_sof), .out_eof(s_eof)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_base = 0, m_frame = 0;
  bit m_away = 0;
  logic e_valid, e_sof, e_eof, e_cnt, e_restart;
  logic [DW-1:0] e_data;
  string r_v, r_f, r_d;

  always @(posedge clk) begin
    e_valid = 0; e_sof = 0; e_eof = 0; e_cnt = 0; e_restart = 0; e_data = '0;
    if (rst) begin
      m_base = 0; m_frame = 0; m_away = 0;
      r_v = "R1"; r_f = "R1"; r_d = "R1";
    end else begin
      r_v = "R8"; r_f = "R8"; r_d = "R8";
      if (!cap_en) begin
        r_v = "R9"; r_f = "R9"; r_d = "R9";
      end else if (mode_sel == 2'd0) begin
        e_valid = chan_valid; e_sof = chan_valid & chan_sof; e_eof = chan_valid & chan_eof;
        e_data = chan_valid ? chan_data : '0;
      end else if (mode_sel == 2'd1) begin
        e_valid = byp_valid; e_sof = byp_valid & byp_sof; e_eof = byp_valid & byp_eof;
        e_data = byp_valid ? byp_data : '0;
      end else if (mode_sel == 2'd2) begin
        if (sw_trig) begin
          r_v = "R7"; r_f = "R7"; r_d = "R7";
        end else begin
          e_valid = 1; e_cnt = 1;
          e_sof = (m_base == 0); e_eof = (m_base == FL - LANES);
          for (int k = 0; k < LANES; k++) begin
            e_data[k*32 +: 16]    = 16'(m_base + k);
            e_data[k*32+16 +: 16] = 16'(m_frame);
          end
          r_v = "R6"; r_f = "R5"; r_d = m_away ? "R10" : "R2";
        end
      end
      if (sw_trig) begin
        m_base = 0; m_frame = 0; e_restart = 1; m_away = 0;
      end else if (e_cnt) begin
        m_away = 0;
        if (m_base == FL - LANES) begin m_base = 0; m_frame = (m_frame + 1) % 65536; end
        else m_base = m_base + LANES;
      end else if (mode_sel != 2'd2) begin
        m_away = 1;
      end
    end
  end

  int s_beats = 0;
  int s_e_l0, s_e_fr;
  bit s_e_v = 0;
  always @(posedge clk) begin
    if (rst) begin s_beats = 0; s_e_v = 0; end
    else begin
      s_e_v = 1;
      s_e_l0 = (s_beats % 2) * LANES;
      s_e_fr = (s_beats / 2) % 65536;
      s_beats++;
    end
  end

  // ---------------- comparison, away from the edge ----------------
  bit have_prev = 0;
  int prev_last, prev_frame;
  bit seen_roll = 0;

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    chk(out_valid === e_valid, r_v, DW'(out_valid), DW'(e_valid));
    chk(out_sof === e_sof, r_f, DW'(out_sof), DW'(e_sof));
    chk(out_eof === e_eof, r_f, DW'(out_eof), DW'(e_eof));
    chk(out_data === e_data, r_d, out_data, e_data);
    if (e_restart) have_prev = 0;
    if (e_cnt) begin
      if (have_prev) begin
        int d;
        d = int'(out_data[15:0]) - prev_last;
        // R3: +1 step between samples, -(FL-1) at the wrap
        chk(d == 1 || d == -(FL - 1), "R3", DW'(out_data[15:0]), DW'(prev_last));
        if (d == -(FL - 1))
          chk(int'(out_data[31:16]) == (prev_frame + 1) % 65536, "R4",
              DW'(out_data[31:16]), DW'((prev_frame + 1) % 65536));
      end
      have_prev = 1;
      prev_last = int'(out_data[(LANES-1)*32 +: 16]);
      prev_frame = int'(out_data[31:16]);
    end
    if (s_e_v) begin
      chk(s_valid === 1'b1, "R6", DW'(s_valid), DW'(1));
      chk(int'(s_data[15:0]) == s_e_l0, "R3", DW'(s_data[15:0]), DW'(s_e_l0));
      chk(int'(s_data[31:16]) == s_e_fr, "R4", DW'(s_data[31:16]), DW'(s_e_fr));
      if (s_beats == 2 * 65536 + 1) begin
        seen_roll = 1;
        // R4: frame index rollover 65535 -> 0
        chk(s_data[31:16] == 16'd0 && s_data[15:0] == 16'd0, "R4",
            DW'(s_data[31:0]), DW'(0));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      chan_data  = {$urandom, $urandom, $urandom, $urandom};
      byp_data   = {$urandom, $urandom, $urandom, $urandom};
      chan_valid = 1'($urandom % 2); chan_sof = 1'($urandom % 2); chan_eof = 1'($urandom % 2);
      byp_valid  = 1'($urandom % 2); byp_sof  = 1'($urandom % 2); byp_eof  = 1'($urandom % 2);
    end
  endtask

  bit done = 0;

  initial begin
    step(4);
    // R1: reset state
    chk(out_valid === 1'b0 && out_data === '0, "R1", out_data, '0);
    rst = 1'b0;
    cap_en = 1'b1;
    mode_sel = 2'd0; step(20);          // R8 channelizer
    mode_sel = 2'd1; step(20);          // R8 bypass
    mode_sel = 2'd2; step(300);         // R2 R3 R5 R6, two wraps
    cap_en = 1'b0;   step(10);          // R9 gate and hold
    cap_en = 1'b1;   step(7);
    mode_sel = 2'd0; step(10);          // R10 hold while away
    mode_sel = 2'd2; step(50);
    sw_trig = 1'b1;  step(1);           // R7 mid-frame
    sw_trig = 1'b0;  step(40);
    while (m_base != FL - LANES) step(1);
    sw_trig = 1'b1;  step(1);           // R7 trigger on the end-of-frame beat
    sw_trig = 1'b0;  step(20);
    mode_sel = 2'd3; step(5);           // R8 no source
    for (int i = 0; i < 2000; i++) begin
      mode_sel = ($urandom % 8 == 0) ? 2'(($urandom % 2)) : 2'd2;
      cap_en   = ($urandom % 5 != 0);
      sw_trig  = ($urandom % 50 == 0);
      step(1);
    end
    mode_sel = 2'd2; cap_en = 1'b1; sw_trig = 1'b0;
    while (s_beats < 2 * 65536 + 8) step(1);
    chk(seen_roll, "R4", DW'(seen_roll), DW'(1));
    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule